// File: doc/BRIEF.md
# Explicit Forwarding Result Register Stage

This block sits at the end of the execute stage of a short in-order pipeline that has two function units. Unit 0 is the load-store unit and unit 1 is the ALU. Each unit has an end-of-execute result register, and software can address that register by name. An instruction that names a unit's forwarding register as a source receives the result of the last instruction that unit completed. An instruction that names a forwarding register as its destination leaves its result in that register, and the general register file is not written.

The result register is clock-enabled. It keeps its value through interlock stalls, NOP slots and loads, so a value can be forwarded explicitly between instructions that issue several cycles apart. The block also selects each source operand from three places: the forwarding registers, the conventional name-matched bypass from the execute and write-back stages, and the register-file read data. It drives one register-file write port per unit from the write-back stage, and it drops the write when the destination is not a general register. Decode, the unit arithmetic, the register file, memory and exception recovery are outside the block.

Top module: `efr_fwd_stage`

## Requirements
- R1: Reset clears both forwarding registers to zero and cancels any pending write-back. After reset, reading name 32 or 33 returns 0 and `rf_we` is low.
- R2: When unit u has a valid non-load instruction in execute and `stall` is low, its result is captured at the clock edge. From the next cycle, source name 32+u (32 for the load-store unit, 33 for the ALU) returns that result.
- R3: In a cycle with `stall` high, no forwarding register changes and no new write-back is started.
- R4: A NOP slot (`ex_valid` low) leaves that unit's forwarding register unchanged.
- R5: A load (`ex_load` high) leaves that unit's forwarding register unchanged and causes no register-file write from this block.
- R6: A captured instruction whose destination name is 0 to 31 gives exactly one cycle of `rf_we`, in the cycle after capture. In that cycle `rf_waddr` is the destination and `rf_wdata` is the result.
- R7: A captured instruction whose destination name is 32 or above never asserts `rf_we`.
- R8: Source name 32+u always returns forwarding register u. This applies even when a bypass match or register-file data exists, and even while unit u writes that register in the same cycle, in which case the old value is returned.
- R9: For a source name 0 to 31 that matches the destination of a valid non-load instruction in execute, the operand is that instruction's result. This match wins over a write-back match.
- R10: For a source name 0 to 31 that matches a pending write-back destination and has no execute match, the operand is the write-back result.
- R11: Any other source name, including 34 to 63 and names with no pending match, takes `rf_rdata`. Names of 32 and above never take part in bypass matching.
- R12: When both units match the same name in the same stage, the ALU (unit 1) wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Interlock: freezes the execute-stage result registers |
| ex_valid | input | NUM_UNITS | A non-NOP instruction occupies the unit's execute stage |
| ex_load | input | NUM_UNITS | The execute-stage instruction is a load |
| ex_dst | input | NUM_UNITS x NAME_W | Destination name (0-31 general, 32+u forwarding) |
| ex_result | input | NUM_UNITS x DATA_W | Result computed by the unit this cycle |
| src_name | input | NUM_RD x NAME_W | Source operand names to resolve |
| rf_rdata | input | NUM_RD x DATA_W | Register-file read data for each source |
| opnd | output | NUM_RD x DATA_W | Resolved operand values |
| rf_we | output | NUM_UNITS | Register-file write enable per unit |
| rf_waddr | output | NUM_UNITS x GPR_W | Register-file write address |
| rf_wdata | output | NUM_UNITS x DATA_W | Register-file write data |

## Verification
A corrupted or wrongly enabled result register appears on `opnd` in the first cycle after the faulty edge, provided a source names 32 or 33. The bench therefore reads those names after each stall, NOP and load slot. A wrong write-back tag appears one cycle after capture on `rf_we`, `rf_waddr` or `rf_wdata`. A missing stage-clear appears as a duplicated write or a stale bypass in the cycle that follows. A wrong select priority shows up in the same cycle, on the operand of a source that matches more than one place.

// File: rtl/efr_pkg.sv
package efr_pkg;

  typedef enum logic [1:0] {
    SRC_RF  = 2'd0,
    SRC_WB  = 2'd1,
    SRC_EX  = 2'd2,
    SRC_FWD = 2'd3
  } opsrc_e;

  // A general register name lies below the general register count.
  function automatic bit is_gpr(input int name, input int ngpr);
    return name < ngpr;
  endfunction

  // Forwarding register names follow directly after the general names.
  function automatic bit is_fwd_name(input int name, input int ngpr, input int nunit);
    return (name >= ngpr) && (name < ngpr + nunit);
  endfunction

endpackage

// File: rtl/efr_result_reg.sv
module efr_result_reg #(
  parameter int DW   = 32,
  parameter int NGPR = 32,
  parameter int NW   = 6,
  parameter int GW   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall,
  input  logic          ex_valid,
  input  logic          ex_load,
  input  logic [NW-1:0] ex_dst,
  input  logic [DW-1:0] ex_result,
  output logic [DW-1:0] fwd_q,
  output logic [NW-1:0] wb_dst_q,
  output logic          ex_byp_ok,
  output logic          wb_byp_ok,
  output logic          rf_we,
  output logic [GW-1:0] rf_waddr,
  output logic [DW-1:0] rf_wdata
);
  import efr_pkg::*;

  logic cap;     // capture event: result enters the forwarding register
  logic wb_vld_q;

  assign cap       = ex_valid && !ex_load && !stall;
  assign ex_byp_ok = ex_valid && !ex_load && is_gpr(int'(ex_dst), NGPR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_q    <= '0;
      wb_dst_q <= '0;
      wb_vld_q <= 1'b0;
    end else begin
      wb_vld_q <= cap;
      if (cap) begin
        fwd_q    <= ex_result;
        wb_dst_q <= ex_dst;
      end
    end
  end

  assign wb_byp_ok = wb_vld_q && is_gpr(int'(wb_dst_q), NGPR);
  assign rf_we     = wb_byp_ok;
  assign rf_waddr  = wb_dst_q[GW-1:0];
  assign rf_wdata  = fwd_q;

endmodule

// File: rtl/efr_operand_mux.sv
module efr_operand_mux #(
  parameter int DW   = 32,
  parameter int NGPR = 32,
  parameter int NU   = 2,
  parameter int NW   = 6
) (
  input  logic [NW-1:0]         src_name,
  input  logic [DW-1:0]         rf_rdata,
  input  logic [NU-1:0][DW-1:0] fwd_q,
  input  logic [NU-1:0][NW-1:0] wb_dst,
  input  logic [NU-1:0]         wb_ok,
  input  logic [NU-1:0][DW-1:0] ex_result,
  input  logic [NU-1:0][NW-1:0] ex_dst,
  input  logic [NU-1:0]         ex_ok,
  output logic [DW-1:0]         opnd
);
  import efr_pkg::*;

  opsrc_e        sel;
  logic          name_fwd;
  logic          ex_hit;
  logic          wb_hit;
  logic [DW-1:0] fwd_val;
  logic [DW-1:0] ex_val;
  logic [DW-1:0] wb_val;

  assign name_fwd = is_fwd_name(int'(src_name), NGPR, NU);

  // Higher unit index is scanned last, so it wins a same-stage tie.
  always_comb begin
    ex_hit  = 1'b0;
    wb_hit  = 1'b0;
    fwd_val = '0;
    ex_val  = '0;
    wb_val  = '0;
    for (int u = 0; u < NU; u++) begin
      if (src_name == NW'(NGPR + u)) fwd_val = fwd_q[u];
      if (wb_ok[u] && (wb_dst[u] == src_name)) begin
        wb_hit = 1'b1;
        wb_val = fwd_q[u];
      end
      if (ex_ok[u] && (ex_dst[u] == src_name)) begin
        ex_hit = 1'b1;
        ex_val = ex_result[u];
      end
    end
  end

  always_comb begin
    if (name_fwd)    sel = SRC_FWD;
    else if (ex_hit) sel = SRC_EX;
    else if (wb_hit) sel = SRC_WB;
    else             sel = SRC_RF;
  end

  always_comb begin
    case (sel)
      SRC_FWD: opnd = fwd_val;
      SRC_EX:  opnd = ex_val;
      SRC_WB:  opnd = wb_val;
      default: opnd = rf_rdata;
    endcase
  end

endmodule

// File: rtl/efr_fwd_stage.sv
module efr_fwd_stage #(
  parameter  int DATA_W    = 32,
  parameter  int NUM_GPR   = 32,
  parameter  int NUM_UNITS = 2,
  parameter  int NUM_RD    = 2,
  localparam int NAME_W    = $clog2(NUM_GPR + NUM_UNITS),
  localparam int GPR_W     = $clog2(NUM_GPR)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               stall,
  input  logic [NUM_UNITS-1:0]               ex_valid,
  input  logic [NUM_UNITS-1:0]               ex_load,
  input  logic [NUM_UNITS-1:0][NAME_W-1:0]   ex_dst,
  input  logic [NUM_UNITS-1:0][DATA_W-1:0]   ex_result,
  input  logic [NUM_RD-1:0][NAME_W-1:0]      src_name,
  input  logic [NUM_RD-1:0][DATA_W-1:0]      rf_rdata,
  output logic [NUM_RD-1:0][DATA_W-1:0]      opnd,
  output logic [NUM_UNITS-1:0]               rf_we,
  output logic [NUM_UNITS-1:0][GPR_W-1:0]    rf_waddr,
  output logic [NUM_UNITS-1:0][DATA_W-1:0]   rf_wdata
);

  logic [NUM_UNITS-1:0][DATA_W-1:0] fwd_q;
  logic [NUM_UNITS-1:0][NAME_W-1:0] wb_dst;
  logic [NUM_UNITS-1:0]             ex_ok;
  logic [NUM_UNITS-1:0]             wb_ok;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    efr_result_reg #(
      .DW(DATA_W), .NGPR(NUM_GPR), .NW(NAME_W), .GW(GPR_W)
    ) u_res (
      .clk       (clk),
      .rst_n     (rst_n),
      .stall     (stall),
      .ex_valid  (ex_valid[u]),
      .ex_load   (ex_load[u]),
      .ex_dst    (ex_dst[u]),
      .ex_result (ex_result[u]),
      .fwd_q     (fwd_q[u]),
      .wb_dst_q  (wb_dst[u]),
      .ex_byp_ok (ex_ok[u]),
      .wb_byp_ok (wb_ok[u]),
      .rf_we     (rf_we[u]),
      .rf_waddr  (rf_waddr[u]),
      .rf_wdata  (rf_wdata[u])
    );
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    efr_operand_mux #(
      .DW(DATA_W), .NGPR(NUM_GPR), .NU(NUM_UNITS), .NW(NAME_W)
    ) u_mux (
      .src_name  (src_name[r]),
      .rf_rdata  (rf_rdata[r]),
      .fwd_q     (fwd_q),
      .wb_dst    (wb_dst),
      .wb_ok     (wb_ok),
      .ex_result (ex_result),
      .ex_dst    (ex_dst),
      .ex_ok     (ex_ok),
      .opnd      (opnd[r])
    );
  end

endmodule

// File: rtl/efr_fwd_checker.sv
module efr_fwd_checker #(
  parameter int DW   = 32,
  parameter int NGPR = 32,
  parameter int NU   = 2,
  parameter int NR   = 2,
  parameter int NW   = 6,
  parameter int GW   = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  stall,
  input logic [NU-1:0]         ex_valid,
  input logic [NU-1:0]         ex_load,
  input logic [NU-1:0][NW-1:0] ex_dst,
  input logic [NU-1:0][DW-1:0] ex_result,
  input logic [NR-1:0][NW-1:0] src_name,
  input logic [NR-1:0][DW-1:0] opnd,
  input logic [NU-1:0]         rf_we,
  input logic [NU-1:0][GW-1:0] rf_waddr,
  input logic [NU-1:0][DW-1:0] rf_wdata,
  input logic [NU-1:0][DW-1:0] fwd_q
);
  localparam logic [NW-1:0] GPR_LIM = NW'(NGPR);

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  for (genvar u = 0; u < NU; u++) begin : g_u
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> (fwd_q[u] == '0) && !rf_we[u]);

    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(ex_valid[u] && !ex_load[u] && !stall) |-> fwd_q[u] == $past(ex_result[u]));

    assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(stall) |-> $stable(fwd_q[u]) && !rf_we[u]);

    assert_nop_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(!ex_valid[u]) |-> $stable(fwd_q[u]));

    assert_load_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(ex_load[u]) |-> $stable(fwd_q[u]) && !rf_we[u]);

    assert_wb_origin_R6: assert property (@(posedge clk) disable iff (!rst_n)
      armed && rf_we[u] |-> $past(ex_valid[u] && !ex_load[u] && !stall)
        && ($past(ex_dst[u]) < GPR_LIM)
        && (rf_waddr[u] == $past(ex_dst[u][GW-1:0]))
        && (rf_wdata[u] == $past(ex_result[u])));

    assert_no_rf_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(ex_valid[u] && !ex_load[u] && !stall && (ex_dst[u] >= GPR_LIM))
        |-> !rf_we[u]);

    for (genvar r = 0; r < NR; r++) begin : g_r
      assert_explicit_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (src_name[r] == NW'(NGPR + u)) |-> opnd[r] == fwd_q[u]);
    end
  end

endmodule

bind efr_fwd_stage efr_fwd_checker #(
  .DW(DATA_W), .NGPR(NUM_GPR), .NU(NUM_UNITS), .NR(NUM_RD), .NW(NAME_W), .GW(GPR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .stall     (stall),
  .ex_valid  (ex_valid),
  .ex_load   (ex_load),
  .ex_dst    (ex_dst),
  .ex_result (ex_result),
  .src_name  (src_name),
  .opnd      (opnd),
  .rf_we     (rf_we),
  .rf_waddr  (rf_waddr),
  .rf_wdata  (rf_wdata),
  .fwd_q     (fwd_q)
);

// File: tb/sim_efr_fwd_stage.sv
`timescale 1ns/1ps
module sim_efr_fwd_stage;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              stall;
  logic [1:0]        ex_valid, ex_load;
  logic [1:0][5:0]   ex_dst;
  logic [1:0][31:0]  ex_result;
  logic [1:0][5:0]   src_name;
  logic [1:0][31:0]  rf_rdata;
  logic [1:0][31:0]  opnd;
  logic [1:0]        rf_we;
  logic [1:0][4:0]   rf_waddr;
  logic [1:0][31:0]  rf_wdata;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;  // 50 MHz

  efr_fwd_stage u0 (
    .clk(clk), .rst_n(rst_n), .stall(stall), .ex_valid(ex_valid), .ex_load(ex_load),
    .ex_dst(ex_dst), .ex_result(ex_result), .src_name(src_name), .rf_rdata(rf_rdata),
    .opnd(opnd), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
  );

  // One row per cycle: ALU (unit 1) stimulus, read port 0, expected results.
  typedef struct packed {
    logic        stl;
    logic        vld;
    logic        ld;
    logic [5:0]  dst;
    logic [31:0] res;
    logic [5:0]  src;
    logic [31:0] rfd;
    logic [31:0] exp_op;
    logic        exp_we;
    logic [4:0]  exp_wa;
    logic [31:0] exp_wd;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    // R8: explicit name returns old value while the ALU writes it
    '{1'b0,1'b1,1'b0,6'd33,32'h1111_0001,6'd33,32'hCAFE_0000,32'h0000_0000,1'b0,5'd0,32'h0,4'd8},
    // R3: stalled slot, R7: previous destination was name 33
    '{1'b1,1'b1,1'b0,6'd5, 32'h2222_0005,6'd33,32'hCAFE_0001,32'h1111_0001,1'b0,5'd0,32'h0,4'd3},
    // R4: NOP slot keeps the value
    '{1'b0,1'b0,1'b0,6'd5, 32'h2222_0005,6'd33,32'hCAFE_0002,32'h1111_0001,1'b0,5'd0,32'h0,4'd4},
    // R5: load slot keeps the value
    '{1'b0,1'b1,1'b1,6'd7, 32'h3333_0007,6'd33,32'hCAFE_0003,32'h1111_0001,1'b0,5'd0,32'h0,4'd5},
    // R9: execute-stage bypass
    '{1'b0,1'b1,1'b0,6'd5, 32'h2222_0005,6'd5, 32'hDEAD_0005,32'h2222_0005,1'b0,5'd0,32'h0,4'd9},
    // R10: write-back bypass; R6: write of r5
    '{1'b0,1'b1,1'b0,6'd6, 32'h4444_0006,6'd5, 32'hDEAD_0005,32'h2222_0005,1'b1,5'd5,32'h2222_0005,4'd10},
    // R9: execute beats write-back on r6
    '{1'b0,1'b1,1'b0,6'd6, 32'h5555_0006,6'd6, 32'hDEAD_0006,32'h5555_0006,1'b1,5'd6,32'h4444_0006,4'd9},
    // R11: no match, register file data; R6 write of r6
    '{1'b0,1'b0,1'b0,6'd0, 32'h0,        6'd9, 32'h1234_0009,32'h1234_0009,1'b1,5'd6,32'h5555_0006,4'd11},
    // R11: write-back gone, register file data
    '{1'b0,1'b0,1'b0,6'd0, 32'h0,        6'd6, 32'h5678_0006,32'h5678_0006,1'b0,5'd0,32'h0,4'd11},
    // R11: name 40 is never bypassed
    '{1'b0,1'b1,1'b0,6'd40,32'h6666_0028,6'd40,32'h7777_0028,32'h7777_0028,1'b0,5'd0,32'h0,4'd11},
    // R7: destination 40 does not write; R2 value captured
    '{1'b0,1'b0,1'b0,6'd0, 32'h0,        6'd33,32'hCAFE_0004,32'h6666_0028,1'b0,5'd0,32'h0,4'd7}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    stall = 1'b0; ex_valid = '0; ex_load = '0; ex_dst = '0; ex_result = '0;
    src_name = '0; rf_rdata = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    src_name[0] = 6'd32; src_name[1] = 6'd33;
    #5;
    check("R1 lsu fwd", opnd[0], 32'h0);
    check("R1 alu fwd", opnd[1], 32'h0);
    check("R1 rf_we", {30'h0, rf_we}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      idle();
      stall        = TBL[i].stl;
      ex_valid[1]  = TBL[i].vld;
      ex_load[1]   = TBL[i].ld;
      ex_dst[1]    = TBL[i].dst;
      ex_result[1] = TBL[i].res;
      src_name[0]  = TBL[i].src;
      rf_rdata[0]  = TBL[i].rfd;
      #5;
      check($sformatf("R%0d row %0d opnd", TBL[i].req, i), opnd[0], TBL[i].exp_op);
      check($sformatf("R%0d row %0d we", TBL[i].req, i), {31'h0, rf_we[1]}, {31'h0, TBL[i].exp_we});
      if (TBL[i].exp_we) begin
        check($sformatf("R%0d row %0d waddr", TBL[i].req, i), {27'h0, rf_waddr[1]}, {27'h0, TBL[i].exp_wa});
        check($sformatf("R%0d row %0d wdata", TBL[i].req, i), rf_wdata[1], TBL[i].exp_wd);
      end
    end

    // R2: load-store unit captures to its forwarding register, ALU writes r3
    @(negedge clk);
    idle();
    ex_valid = 2'b11;
    ex_dst[0] = 6'd32; ex_result[0] = 32'hAAAA_0020;
    ex_dst[1] = 6'd3;  ex_result[1] = 32'hBBBB_0003;
    @(negedge clk);
    idle();
    src_name[0] = 6'd32; src_name[1] = 6'd33;
    #5;
    check("R2 lsu fwd read", opnd[0], 32'hAAAA_0020);
    check("R2 alu fwd read", opnd[1], 32'hBBBB_0003);
    check("R7 lsu no write", {31'h0, rf_we[0]}, 32'h0);
    check("R6 alu write r3", {26'h0, rf_we[1], rf_waddr[1]}, {26'h0, 1'b1, 5'd3});

    // R12: both units target r12 in the same cycle
    @(negedge clk);
    idle();
    ex_valid = 2'b11;
    ex_dst[0] = 6'd12; ex_result[0] = 32'hC000_000C;
    ex_dst[1] = 6'd12; ex_result[1] = 32'hC111_000C;
    src_name[0] = 6'd12; rf_rdata[0] = 32'hF00D_000C;
    #5;
    check("R12 execute tie", opnd[0], 32'hC111_000C);
    @(negedge clk);
    idle();
    src_name[1] = 6'd12; rf_rdata[1] = 32'hF00D_000C;
    #5;
    check("R12 write-back tie", opnd[1], 32'hC111_000C);
    check("R6 both units write", {30'h0, rf_we}, 32'h3);

    // R1: reset in mid-run clears the forwarding registers
    @(negedge clk);
    idle();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    src_name[0] = 6'd32; src_name[1] = 6'd33;
    #5;
    check("R1 lsu after reset", opnd[0], 32'h0);
    check("R1 alu after reset", opnd[1], 32'h0);
    check("R1 rf_we after reset", {30'h0, rf_we}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule